// File: doc/BRIEF.md
# RAM-Modulated DDS Tuning Core

This block is the phase engine of a direct digital synthesizer. A 24-bit phase accumulator advances by a live tuning word on every sample clock. The top bits of the accumulator, plus a phase offset, form a 16-bit output phase. An amplitude lookup table further down the chain turns that phase into a sine or a cosine sample. Cosine is made by adding a quarter turn to the phase before it leaves the block.

The tuning word and the phase offset each come from one of two sources: a control register, or a 14-bit word streamed from a pattern memory. In memory mode, the memory word is spliced into the live tuning word at a bit position set by a 5-bit shift code. The upper bits of the tuning word above the splice are kept, which allows frequency sweeps and chirps at a chosen resolution. The block also emits the strobe that advances the pattern-memory address. That strobe fires either on every sample clock or once per accumulator wrap, marked by a rising edge of accumulator bit 23.

Top module: `dds_tune_core`

## Requirements
- R1: While rst_ni is low, phase_o is 0, addr_adv_o is 0, and the accumulator and the live tuning word are cleared.
- R2: With tw_mem_en_i = 0, the live tuning word loads reg_tw_i at every clock edge.
- R3: With tw_mem_en_i = 1 and shift code n in 0..10, the next live tuning word is formed, from MSB down, by: the current word's top n bits, then mem_data_i[13:0], then (10 - n) zero bits.
- R4: With tw_mem_en_i = 1 and shift code n in 11..16, the next live tuning word is formed, from MSB down, by: current bits 23 down to (24 - n), then mem_data_i[13:(n - 10)].
- R5: With tw_mem_en_i = 1 and a shift code from 17 to 31, the live tuning word holds its value.
- R6: The accumulator adds the live tuning word at every edge, modulo 2^24. After edge k, phase_o equals accumulator bits [23:8] as of edge k-1, plus the offset and the cosine term sampled at edge k, modulo 2^16. The live tuning word set at edge k therefore reaches phase_o two edges later.
- R7: With ph_mem_en_i = 1, the phase offset is {mem_data_i, 2'b00}. With ph_mem_en_i = 0, it is reg_phase_i.
- R8: With cos_en_i = 1, 0x4000 is added to phase_o. With cos_en_i = 0, nothing is added.
- R9: With msb_clk_en_i = 0 at an edge, addr_adv_o is 1 after that edge.
- R10: With msb_clk_en_i = 1 at an edge, addr_adv_o is 1 after that edge only if accumulator bit 23 was 1 at that edge and 0 at the edge before. This gives a one-cycle pulse for each 0-to-1 transition of bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cos_en_i | input | 1 | Select cosine (quarter-turn phase advance) |
| msb_clk_en_i | input | 1 | 0: address strobe every cycle; 1: strobe on accumulator MSB rise |
| ph_mem_en_i | input | 1 | 1: phase offset from memory word; 0: from reg_phase_i |
| tw_mem_en_i | input | 1 | 1: merge memory word into tuning word; 0: use reg_tw_i |
| shift_code_i | input | 5 | Merge position code, 0..16 valid |
| reg_tw_i | input | 24 | Register tuning word |
| reg_phase_i | input | 16 | Register phase offset |
| mem_data_i | input | 14 | Pattern-memory data word |
| phase_o | output | 16 | Offset output phase |
| addr_adv_o | output | 1 | Pattern-memory address advance strobe |

## Verification
The bench builds the core with its default widths: a 24-bit accumulator, a 14-bit memory word, a 16-bit output phase and a highest valid shift code of 16. With these widths, the full 5-bit code space can be driven from a random draw, so every splice position and every reserved code is reached. Large random tuning words wrap the 24-bit accumulator often, which exercises modulo wrap and frequent bit-23 rises. A directed step of 0x100000 gives an exact 16-cycle strobe period in MSB mode.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int unsigned DEF_ACC_W     = 24;
  localparam int unsigned DEF_MEM_W     = 14;
  localparam int unsigned DEF_OUT_W     = 16;
  localparam int unsigned DEF_SHIFT_W   = 5;
  localparam int unsigned DEF_MAX_SHIFT = 16;

  typedef struct packed {
    logic cos_en;
    logic msb_clk_en;
    logic ph_mem_en;
    logic tw_mem_en;
  } dds_cfg_t;
endpackage

// File: rtl/dds_tw_merge.sv
module dds_tw_merge #(
  parameter int unsigned ACC_W     = 24,
  parameter int unsigned MEM_W     = 14,
  parameter int unsigned SHIFT_W   = 5,
  parameter int unsigned MAX_SHIFT = 16
) (
  input  logic [ACC_W-1:0]   tw_i,
  input  logic [MEM_W-1:0]   mem_i,
  input  logic [SHIFT_W-1:0] code_i,
  output logic [ACC_W-1:0]   merged_o,
  output logic               code_ok_o
);
  localparam int unsigned N_CODES = MAX_SHIFT + 1;
  localparam int unsigned PAD_W   = ACC_W - MEM_W;

  logic [ACC_W-1:0] aligned;
  logic [ACC_W-1:0] cand [N_CODES];

  assign aligned = {mem_i, {PAD_W{1'b0}}};

  // one candidate per code: keep top g bits, shift aligned word down by g
  for (genvar g = 0; g < N_CODES; g++) begin : g_cand
    localparam logic [ACC_W-1:0] KEEP = ~({ACC_W{1'b1}} >> g);
    assign cand[g] = (tw_i & KEEP) | (aligned >> g);
  end

  always_comb begin
    merged_o  = tw_i;
    code_ok_o = 1'b0;
    for (int k = 0; k < N_CODES; k++) begin
      if (code_i == SHIFT_W'(k)) begin
        merged_o  = cand[k];
        code_ok_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int unsigned ACC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] step_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             msb_rise_o
);
  logic [ACC_W-1:0] acc_q;
  logic             msb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      msb_q <= 1'b0;
    end else begin
      acc_q <= acc_q + step_i;
      msb_q <= acc_q[ACC_W-1];
    end
  end

  assign acc_o      = acc_q;
  assign msb_rise_o = acc_q[ACC_W-1] & ~msb_q;
endmodule

// File: rtl/dds_phase_out.sv
module dds_phase_out #(
  parameter int unsigned OUT_W = 16,
  parameter int unsigned MEM_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OUT_W-1:0] acc_top_i,
  input  logic [MEM_W-1:0] mem_i,
  input  logic [OUT_W-1:0] reg_phase_i,
  input  logic             ph_mem_en_i,
  input  logic             cos_en_i,
  output logic [OUT_W-1:0] phase_o
);
  localparam logic [OUT_W-1:0] QUARTER = OUT_W'(1) << (OUT_W - 2);

  logic [OUT_W-1:0] mem_off;
  logic [OUT_W-1:0] offset;
  logic [OUT_W-1:0] phase_q;

  // memory word is left-aligned into the offset field
  if (OUT_W > MEM_W) begin : g_pad
    assign mem_off = {mem_i, {(OUT_W - MEM_W){1'b0}}};
  end else begin : g_trunc
    assign mem_off = mem_i[MEM_W-1 -: OUT_W];
  end

  assign offset = ph_mem_en_i ? mem_off : reg_phase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= acc_top_i + offset + (cos_en_i ? QUARTER : '0);
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/dds_tune_core.sv
module dds_tune_core
  import dds_pkg::*;
#(
  parameter int unsigned ACC_W     = DEF_ACC_W,
  parameter int unsigned MEM_W     = DEF_MEM_W,
  parameter int unsigned OUT_W     = DEF_OUT_W,
  parameter int unsigned SHIFT_W   = DEF_SHIFT_W,
  parameter int unsigned MAX_SHIFT = DEF_MAX_SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cos_en_i,
  input  logic               msb_clk_en_i,
  input  logic               ph_mem_en_i,
  input  logic               tw_mem_en_i,
  input  logic [SHIFT_W-1:0] shift_code_i,
  input  logic [ACC_W-1:0]   reg_tw_i,
  input  logic [OUT_W-1:0]   reg_phase_i,
  input  logic [MEM_W-1:0]   mem_data_i,
  output logic [OUT_W-1:0]   phase_o,
  output logic               addr_adv_o
);
  dds_cfg_t         cfg;
  logic [ACC_W-1:0] tw_q;
  logic [ACC_W-1:0] merged;
  logic             code_ok;
  logic [ACC_W-1:0] acc_q;
  logic             msb_rise;
  logic             adv_q;

  assign cfg = '{cos_en: cos_en_i, msb_clk_en: msb_clk_en_i,
                 ph_mem_en: ph_mem_en_i, tw_mem_en: tw_mem_en_i};

  dds_tw_merge #(
    .ACC_W(ACC_W), .MEM_W(MEM_W), .SHIFT_W(SHIFT_W), .MAX_SHIFT(MAX_SHIFT)
  ) u_merge (
    .tw_i     (tw_q),
    .mem_i    (mem_data_i),
    .code_i   (shift_code_i),
    .merged_o (merged),
    .code_ok_o(code_ok)
  );

  // live tuning word; reserved codes hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tw_q <= '0;
    else if (!cfg.tw_mem_en) tw_q <= reg_tw_i;
    else if (code_ok)       tw_q <= merged;
  end

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (tw_q),
    .acc_o     (acc_q),
    .msb_rise_o(msb_rise)
  );

  dds_phase_out #(.OUT_W(OUT_W), .MEM_W(MEM_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_top_i  (acc_q[ACC_W-1 -: OUT_W]),
    .mem_i      (mem_data_i),
    .reg_phase_i(reg_phase_i),
    .ph_mem_en_i(cfg.ph_mem_en),
    .cos_en_i   (cfg.cos_en),
    .phase_o    (phase_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) adv_q <= 1'b0;
    else         adv_q <= cfg.msb_clk_en ? msb_rise : 1'b1;
  end

  assign addr_adv_o = adv_q;
endmodule

// File: rtl/dds_tune_core_chk.sv
module dds_tune_core_chk #(
  parameter int unsigned ACC_W     = 24,
  parameter int unsigned SHIFT_W   = 5,
  parameter int unsigned MAX_SHIFT = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msb_clk_en_i,
  input logic               tw_mem_en_i,
  input logic [SHIFT_W-1:0] shift_code_i,
  input logic [ACC_W-1:0]   reg_tw_i,
  input logic [ACC_W-1:0]   tw_q,
  input logic [ACC_W-1:0]   acc_q,
  input logic               addr_adv_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (!addr_adv_o && acc_q == '0 && tw_q == '0)
        else $error("R1 reset state violated");
    end
  end

  a_r2_reg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tw_mem_en_i |=> tw_q == $past(reg_tw_i));

  a_r5_reserved_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tw_mem_en_i && 32'(shift_code_i) > MAX_SHIFT) |=> $stable(tw_q));

  a_r6_acc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> acc_q == ACC_W'($past(acc_q) + $past(tw_q)));

  a_r9_adv_every: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msb_clk_en_i |=> addr_adv_o);

  a_r10_no_pulse_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msb_clk_en_i && !acc_q[ACC_W-1]) |=> !addr_adv_o);
endmodule

bind dds_tune_core dds_tune_core_chk #(
  .ACC_W(ACC_W), .SHIFT_W(SHIFT_W), .MAX_SHIFT(MAX_SHIFT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .msb_clk_en_i(msb_clk_en_i),
  .tw_mem_en_i (tw_mem_en_i),
  .shift_code_i(shift_code_i),
  .reg_tw_i    (reg_tw_i),
  .tw_q        (tw_q),
  .acc_q       (acc_q),
  .addr_adv_o  (addr_adv_o)
);

// File: tb/dds_tune_core_bench.sv
`timescale 1ns/1ps
module dds_tune_core_bench;
  localparam int AW = 24;
  localparam int MW = 14;
  localparam int OW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cos_en, msb_en, ph_mem, tw_mem;
  logic [4:0]    code;
  logic [AW-1:0] reg_tw;
  logic [OW-1:0] reg_ph;
  logic [MW-1:0] mem;
  logic [OW-1:0] phase_o;
  logic          addr_adv_o;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_tag = "R6";

  always #2 clk_i = ~clk_i;

  dds_tune_core u_dds_tune_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .cos_en_i(cos_en), .msb_clk_en_i(msb_en),
    .ph_mem_en_i(ph_mem), .tw_mem_en_i(tw_mem), .shift_code_i(code),
    .reg_tw_i(reg_tw), .reg_phase_i(reg_ph), .mem_data_i(mem),
    .phase_o(phase_o), .addr_adv_o(addr_adv_o)
  );

  // splice per the requirement text, bit by bit
  function automatic logic [AW-1:0] splice(input logic [AW-1:0] cur,
                                           input logic [MW-1:0] m, input int n);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) begin
      if (i >= AW - n)      r[i] = cur[i];
      else if (n <= 10)     r[i] = (i >= 10 - n) ? m[i - (10 - n)] : 1'b0;
      else                  r[i] = m[i + (n - 10)];
    end
    return r;
  endfunction

  logic [AW-1:0] tw_m, acc_m;
  logic [OW-1:0] ph_m;
  logic          adv_m, msbd_m;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tw_m <= '0; acc_m <= '0; ph_m <= '0; adv_m <= 1'b0; msbd_m <= 1'b0;
    end else begin
      if (!tw_mem)            tw_m <= reg_tw;
      else if (code <= 5'd16) tw_m <= splice(tw_m, mem, int'(code));
      acc_m  <= acc_m + tw_m;
      msbd_m <= acc_m[AW-1];
      ph_m   <= acc_m[AW-1 -: OW] + (ph_mem ? {mem, 2'b00} : reg_ph)
                + (cos_en ? 16'h4000 : 16'h0000);
      adv_m  <= msb_en ? (acc_m[AW-1] & ~msbd_m) : 1'b1;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    check(cur_tag, 32'(phase_o), 32'(ph_m));
    check(msb_en ? "R10" : "R9", 32'(addr_adv_o), 32'(adv_m));
  endtask

  task automatic rnd_data();
    reg_tw = AW'($urandom);
    reg_ph = OW'($urandom);
    mem    = MW'($urandom);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    {cos_en, msb_en, ph_mem, tw_mem} = '0;
    code = '0; reg_tw = 24'h0F1234; reg_ph = 16'h1234; mem = 14'h2AAA;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", 32'(phase_o), 32'h0);
    check("R1", 32'(addr_adv_o), 32'h0);
    rst_ni = 1'b1;

    cur_tag = "R2";
    for (int i = 0; i < 200; i++) begin rnd_data(); tick(); end

    // R3: directed extremes then random codes 0..10
    cur_tag = "R3";
    reg_tw = 24'hFFFFFF; tick();
    tw_mem = 1'b1; mem = 14'h3FFF; code = 5'd0; tick();
    code = 5'd10; mem = 14'h0001; tick(); tick(); tick();
    for (int i = 0; i < 300; i++) begin
      rnd_data(); code = 5'($urandom_range(0, 10)); tick();
    end

    cur_tag = "R4";
    tw_mem = 1'b0; reg_tw = 24'hA5A5A5; tick();
    tw_mem = 1'b1; code = 5'd16; mem = 14'h3FC0; tick(); tick(); tick();
    for (int i = 0; i < 300; i++) begin
      rnd_data(); code = 5'($urandom_range(11, 16)); tick();
    end

    cur_tag = "R5";
    tw_mem = 1'b0; reg_tw = 24'h012345; tick();
    tw_mem = 1'b1;
    for (int i = 0; i < 200; i++) begin
      rnd_data(); code = 5'($urandom_range(17, 31)); tick();
    end

    cur_tag = "R7";
    tw_mem = 1'b0;
    for (int i = 0; i < 200; i++) begin
      rnd_data(); ph_mem = 1'($urandom); tick();
    end

    cur_tag = "R8";
    ph_mem = 1'b0; reg_tw = 24'h0; reg_ph = 16'h0; tick(); tick();
    cos_en = 1'b1; tick(); tick();
    for (int i = 0; i < 200; i++) begin
      rnd_data(); cos_en = 1'($urandom); tick();
    end

    // R10: exact 16-cycle wrap, then random steps
    cur_tag = "R10";
    cos_en = 1'b0; msb_en = 1'b1; reg_tw = 24'h100000;
    for (int i = 0; i < 64; i++) tick();
    for (int i = 0; i < 400; i++) begin
      if (i % 8 == 0) reg_tw = AW'($urandom);
      tick();
    end

    cur_tag = "R6";
    reg_tw = 24'hFFFFFF; msb_en = 1'b0;
    for (int i = 0; i < 20; i++) tick();
    for (int i = 0; i < 1000; i++) begin
      rnd_data();
      {cos_en, msb_en, ph_mem, tw_mem} = 4'($urandom);
      code = 5'($urandom);
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule